// File: doc/BRIEF.md
# Manchester ID/Header Frame Decoder

This block takes a single receive line that is sampled OSR times per bit and turns it into framed data. The front end measures how long the line holds each level. A phase slicer uses those run lengths to recover Manchester bits: the value of a bit is the level of its first half. A frame controller then looks for a programmed identifier byte and an optional 4-bit header. It passes the data bits that follow, and it closes the frame when it sees an end-of-message marker. That marker is two whole bit periods at one level, so it is not legal Manchester.

The sender puts an alternating-capable preamble ahead of the identifier, and ahead of the header when the header stage is enabled. The slicer stays in its hunting state until it sees the first run two half-bits long, which must lie at a mid-bit. From then on every transition sets the half-bit phase again. The identifier is accepted in true or inverted form. A header received as 1001 instead of 0110 inverts every data bit that follows, up to the end marker.

Slicer states and transitions:
- SL_HUNT goes to SL_MID on a long run, and that run yields a bit.
- SL_MID goes to SL_BND on a short run. It stays in SL_MID on a long run, which yields a bit. It goes to SL_HUNT on a bad run.
- SL_BND goes to SL_MID on a short run, which yields a bit. It goes to SL_HUNT on a long or bad run.
- Any locked state goes to SL_HUNT on an end marker.

Frame states and transitions:
- FR_ID goes to FR_HDR on an identifier match when the header stage is on, and to FR_DATA when it is off.
- FR_HDR goes to FR_DATA on a header match.
- Any state goes back to FR_ID on a violation or on an end marker.

Top module: `manch_frame_dec`

## Requirements
- R1: A bit is decoded at each mid-bit transition, and its value is the first-half level. The slicer locks on the first run of two half-bits, and each later transition sets the phase again.
- R2: A run of one half-bit is legal only if it spans 45% to 55% of OSR samples. A run of two half-bits is legal only if it spans 90% to 110% of OSR samples. With OSR=16 that means exactly 8 samples, or 15 to 17 samples. Any other run, or a two-half run that starts on a bit boundary, is a violation.
- R3: A violation while locked drops the frame. No further data, header or end pulse is produced until a new identifier is matched.
- R4: The identifier is matched on a sliding 8-bit window of decoded bits, with the first received bit as MSB. It matches when the window equals cfg_id or ~cfg_id. id_found is then high for exactly one clock.
- R5: With hdr_en=1, after the identifier, a 4-bit sliding window (first bit MSB) matching 0110 raises hdr_found, and data passes unchanged. A match on 1001 raises hdr_found, and the data is inverted.
- R6: With hdr_en=0, data bits start with the bit right after the identifier and are never inverted.
- R7: Each data bit raises data_valid for one clock, with data_bit holding the value.
- R8: In the data phase, a level held for 3 half-bits (24 samples at OSR=16) raises eom_found for one clock, emits no extra data bit, and returns to identifier search.
- R9: During reset all output pulses are low.
- R10: At most one of id_found, hdr_found, eom_found and data_valid is high in any cycle. Each rises one clock after the sample that decides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OSR samples per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sample | input | 1 | Sampled receive line |
| cfg_id | input | ID_W | Programmed identifier byte |
| hdr_en | input | 1 | Enables the header stage |
| data_bit | output | 1 | Decoded data bit, after any inversion |
| data_valid | output | 1 | One-clock strobe for data_bit |
| id_found | output | 1 | One-clock identifier match pulse |
| hdr_found | output | 1 | One-clock header match pulse |
| eom_found | output | 1 | One-clock end-of-message pulse |

## Verification
The end marker and the last data bit share one stretch of line. The second half of the final bit can merge into the marker's run, so the marker must fire without emitting a false bit or a false violation. The bench ends frames with each combination of last-bit value and marker level. It judges the result on the exact order of the pulses and checks that no spurious data_valid appears, using a queue of expected events built from the bit pattern it sends. It also sends half-bits of 7 and 9 samples inside the header preamble and inside the data phase, and checks that the frame stops at once with no end pulse.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic [1:0] {RC_SHORT, RC_LONG, RC_BAD} run_cls_e;
    typedef enum logic [1:0] {SL_HUNT, SL_MID, SL_BND} slc_st_e;
    typedef enum logic [1:0] {FR_ID, FR_HDR, FR_DATA} frm_st_e;
    localparam int HDR_W = 4;
    localparam logic [HDR_W-1:0] HDR_TRUE = 4'b0110;
endpackage

// File: rtl/mdec_runlen.sv
module mdec_runlen
    import mdec_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_in,
    output logic     run_end,
    output run_cls_e run_cls,
    output logic     run_lvl,
    output logic     eom_hit
);
    localparam int HALF    = OSR / 2;
    localparam int SH_MIN  = (OSR * 45 + 99) / 100;
    localparam int SH_MAX  = (OSR * 55) / 100;
    localparam int LG_MIN  = (OSR * 90 + 99) / 100;
    localparam int LG_MAX  = (OSR * 110) / 100;
    localparam int EOM_MIN = 3 * HALF;
    localparam int CW      = $clog2(EOM_MIN + 1);
    localparam logic [CW-1:0] C_SH_MIN = CW'(SH_MIN);
    localparam logic [CW-1:0] C_SH_MAX = CW'(SH_MAX);
    localparam logic [CW-1:0] C_LG_MIN = CW'(LG_MIN);
    localparam logic [CW-1:0] C_LG_MAX = CW'(LG_MAX);
    localparam logic [CW-1:0] C_EOM    = CW'(EOM_MIN);

    logic          rx_q;
    logic [CW-1:0] cnt;
    logic          chg;

    assign chg = (rx_in != rx_q);

    // Samples of the current level held so far, saturating at the end-marker length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            cnt  <= '0;
        end else begin
            rx_q <= rx_in;
            if (chg)
                cnt <= CW'(1);
            else if (cnt != C_EOM)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        run_end = chg;
        run_lvl = rx_q;
        eom_hit = !chg && (cnt == C_EOM - 1'b1);
        if (cnt >= C_SH_MIN && cnt <= C_SH_MAX)
            run_cls = RC_SHORT;
        else if (cnt >= C_LG_MIN && cnt <= C_LG_MAX)
            run_cls = RC_LONG;
        else
            run_cls = RC_BAD;
    end
endmodule

// File: rtl/mdec_slicer.sv
module mdec_slicer
    import mdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_end,
    input  run_cls_e run_cls,
    input  logic     run_lvl,
    input  logic     eom_hit,
    output logic     bit_stb,
    output logic     bit_val,
    output logic     viol,
    output logic     eom_stb
);
    slc_st_e st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SL_HUNT;
        else        st <= nxt;
    end

    always_comb begin
        nxt     = st;
        bit_stb = 1'b0;
        bit_val = run_lvl;
        viol    = 1'b0;
        eom_stb = 1'b0;
        if (run_end) begin
            unique case (st)
                SL_HUNT: begin
                    if (run_cls == RC_LONG) begin
                        bit_stb = 1'b1;
                        nxt     = SL_MID;
                    end
                end
                SL_MID: begin
                    if (run_cls == RC_SHORT) begin
                        nxt = SL_BND;
                    end else if (run_cls == RC_LONG) begin
                        bit_stb = 1'b1;
                    end else begin
                        viol = 1'b1;
                        nxt  = SL_HUNT;
                    end
                end
                SL_BND: begin
                    if (run_cls == RC_SHORT) begin
                        bit_stb = 1'b1;
                        nxt     = SL_MID;
                    end else begin
                        viol = 1'b1;
                        nxt  = SL_HUNT;
                    end
                end
                default: nxt = SL_HUNT;
            endcase
        end else if (eom_hit && st != SL_HUNT) begin
            eom_stb = 1'b1;
            nxt     = SL_HUNT;
        end
    end

    p_viol_unlocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (st == SL_HUNT));
    p_eom_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eom_stb |=> (st == SL_HUNT));
    p_lock_needs_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == SL_HUNT && st == SL_MID) |-> $past(run_end));
endmodule

// File: rtl/mdec_frame.sv
module mdec_frame
    import mdec_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_stb,
    input  logic            bit_val,
    input  logic            viol,
    input  logic            eom_stb,
    input  logic [ID_W-1:0] cfg_id,
    input  logic            hdr_en,
    output logic            data_bit,
    output logic            data_valid,
    output logic            id_found,
    output logic            hdr_found,
    output logic            eom_found
);
    localparam int FW = $clog2(ID_W + 1);
    localparam logic [FW-1:0] FILL_ID  = FW'(ID_W - 1);
    localparam logic [FW-1:0] FILL_HDR = FW'(HDR_W - 1);
    localparam logic [FW-1:0] FILL_TOP = FW'(ID_W);

    frm_st_e         st;
    logic [ID_W-1:0] win, win_n;
    logic [FW-1:0]   fill;
    logic            inv;
    logic            id_hit, hdr_hit, hdr_cmp;

    always_comb begin
        win_n   = {win[ID_W-2:0], bit_val};
        id_hit  = bit_stb && st == FR_ID && fill >= FILL_ID
                  && (win_n == cfg_id || win_n == ~cfg_id);
        hdr_cmp = (win_n[HDR_W-1:0] == ~HDR_TRUE);
        hdr_hit = bit_stb && st == FR_HDR && fill >= FILL_HDR
                  && (win_n[HDR_W-1:0] == HDR_TRUE || hdr_cmp);
    end

    // State register with its search windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= FR_ID;
            win  <= '0;
            fill <= '0;
            inv  <= 1'b0;
        end else if (viol || eom_stb) begin
            st   <= FR_ID;
            fill <= '0;
            inv  <= 1'b0;
        end else if (bit_stb) begin
            win <= win_n;
            unique case (st)
                FR_ID: begin
                    if (id_hit) begin
                        st   <= hdr_en ? FR_HDR : FR_DATA;
                        fill <= '0;
                        inv  <= 1'b0;
                    end else if (fill != FILL_TOP) begin
                        fill <= fill + 1'b1;
                    end
                end
                FR_HDR: begin
                    if (hdr_hit) begin
                        st  <= FR_DATA;
                        inv <= hdr_cmp;
                    end else if (fill != FILL_TOP) begin
                        fill <= fill + 1'b1;
                    end
                end
                FR_DATA: ;
                default: st <= FR_ID;
            endcase
        end
    end

    // Registered output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_bit   <= 1'b0;
            data_valid <= 1'b0;
            id_found   <= 1'b0;
            hdr_found  <= 1'b0;
            eom_found  <= 1'b0;
        end else begin
            id_found   <= id_hit;
            hdr_found  <= hdr_hit;
            eom_found  <= eom_stb && st == FR_DATA;
            data_valid <= bit_stb && !viol && st == FR_DATA;
            if (bit_stb && st == FR_DATA)
                data_bit <= bit_val ^ inv;
        end
    end

    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({id_found, hdr_found, eom_found, data_valid}));
    p_id_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        id_found |=> !id_found);
    p_data_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (st == FR_DATA));
    p_eom_to_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eom_found |-> (st == FR_ID));
    p_abort_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (st == FR_ID && !eom_found));
    p_no_inv_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_DATA && $past(st) == FR_ID) |-> !inv);
endmodule

// File: rtl/manch_frame_dec.sv
module manch_frame_dec
    import mdec_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_sample,
    input  logic [ID_W-1:0] cfg_id,
    input  logic            hdr_en,
    output logic            data_bit,
    output logic            data_valid,
    output logic            id_found,
    output logic            hdr_found,
    output logic            eom_found
);
    run_cls_e run_cls;
    logic     run_end, run_lvl, eom_hit;
    logic     bit_stb, bit_val, viol, eom_stb;

    mdec_runlen #(.OSR(OSR)) u_run (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_sample),
        .run_end(run_end), .run_cls(run_cls), .run_lvl(run_lvl), .eom_hit(eom_hit)
    );

    mdec_slicer u_slc (
        .clk(clk), .rst_n(rst_n),
        .run_end(run_end), .run_cls(run_cls), .run_lvl(run_lvl), .eom_hit(eom_hit),
        .bit_stb(bit_stb), .bit_val(bit_val), .viol(viol), .eom_stb(eom_stb)
    );

    mdec_frame #(.ID_W(ID_W)) u_frm (
        .clk(clk), .rst_n(rst_n),
        .bit_stb(bit_stb), .bit_val(bit_val), .viol(viol), .eom_stb(eom_stb),
        .cfg_id(cfg_id), .hdr_en(hdr_en),
        .data_bit(data_bit), .data_valid(data_valid),
        .id_found(id_found), .hdr_found(hdr_found), .eom_found(eom_found)
    );
endmodule

// File: tb/tb_manch_frame_dec.sv
module tb_manch_frame_dec;
    localparam int CLK_PERIOD = 10;
    localparam int OSR  = 16;
    localparam int HALF = OSR / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b0;
    logic       hdr_en = 1'b1;
    logic [7:0] cfg_id = 8'hA7;
    logic       data_bit, data_valid, id_found, hdr_found, eom_found;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    bit done = 1'b0;

    // Event codes: 1 identifier, 2 header, 3 end marker, 4 data 0, 5 data 1
    manch_frame_dec #(.OSR(OSR), .ID_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .rx_sample(rx), .cfg_id(cfg_id), .hdr_en(hdr_en),
        .data_bit(data_bit), .data_valid(data_valid),
        .id_found(id_found), .hdr_found(hdr_found), .eom_found(eom_found)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            1: return "R4 identifier";
            2: return "R5 header";
            3: return "R8 end marker";
            default: return "R7 data bit";
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Behavioural monitor: every pulse is matched against the expected event queue
    always @(negedge clk) begin
        int nev;
        int act;
        int e;
        nev = int'(id_found) + int'(hdr_found) + int'(eom_found) + int'(data_valid);
        if (!rst_n) begin
            check("R9 outputs quiet in reset", nev, 0);
        end else if (!done) begin
            if (nev > 1) begin
                check("R10 one pulse per cycle", nev, 1);
            end else if (nev == 1) begin
                act = id_found ? 1 : hdr_found ? 2 : eom_found ? 3 : (data_bit ? 5 : 4);
                if (exp_q.size() == 0) begin
                    check("R3 unexpected event", act, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(req_of(e), act, e);
                end
            end
        end
    end

    task automatic put(input logic lvl, input int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        put(b, HALF);
        put(~b, HALF);
    endtask

    task automatic send_skew(input logic b, input int first_len);
        put(b, first_len);
        put(~b, HALF);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    // R1: preamble 1110 locks the slicer on the run of two half-bits at its last bit
    task automatic frame(input logic [7:0] id, input logic use_hdr, input logic [1:0] hpre,
                         input logic [3:0] hdr, input logic inv, input logic [7:0] dat,
                         input int nd, input logic eom_lvl);
        exp_q.push_back(1);
        if (use_hdr) exp_q.push_back(2);
        for (int i = nd - 1; i >= 0; i--) exp_q.push_back((dat[i] ^ inv) ? 5 : 4);
        exp_q.push_back(3);
        put(1'b0, 40);
        send_bits(32'b1110, 4);
        send_bits({24'd0, id}, 8);
        if (use_hdr) begin
            send_bits({30'd0, hpre}, 2);
            send_bits({28'd0, hdr}, 4);
        end
        send_bits({24'd0, dat}, nd);
        put(eom_lvl, 2 * OSR);
        put(1'b0, 40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 true header, last data 1 then marker of ones (R8)
        hdr_en = 1'b1;
        frame(8'hA7, 1'b1, 2'b11, 4'b0110, 1'b0, 8'b1011, 4, 1'b1);
        // R4 inverted identifier, R5 inverted header flips data, last 0 then marker of zeros
        frame(8'h58, 1'b1, 2'b00, 4'b1001, 1'b1, 8'b0010, 4, 1'b0);
        // R6 no header stage: data follows the identifier directly
        hdr_en = 1'b0;
        put(1'b0, 8);
        frame(8'hA7, 1'b0, 2'b00, 4'b0000, 1'b0, 8'b11010011, 8, 1'b0);
        frame(8'hA7, 1'b0, 2'b00, 4'b0000, 1'b0, 8'b0110, 4, 1'b1);

        // R2 boundary: a 9-sample half-bit in the header preamble aborts (R3)
        hdr_en = 1'b1;
        put(1'b0, 8);
        exp_q.push_back(1);
        put(1'b0, 40);
        send_bits(32'b1110, 4);
        send_bits(32'hA7, 8);
        send_bits(32'b11, 2);
        send_skew(1'b1, 9);
        put(1'b0, 48);

        // R3: a 7-sample half-bit inside the data phase ends the frame with no marker pulse
        exp_q.push_back(1);
        exp_q.push_back(2);
        exp_q.push_back(5);
        exp_q.push_back(4);
        put(1'b0, 40);
        send_bits(32'b1110, 4);
        send_bits(32'hA7, 8);
        send_bits(32'b11, 2);
        send_bits(32'b0110, 4);
        send_bits(32'b10, 2);
        send_skew(1'b0, 7);
        put(1'b0, 48);

        // Recovery after aborts: a full frame decodes again
        frame(8'hA7, 1'b1, 2'b11, 4'b0110, 1'b0, 8'b1011, 4, 1'b1);

        repeat (20) @(negedge clk);
        check("R7 all expected events seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule